// File: doc/BRIEF.md
# Masked-Write GPIO Port Controller

This block controls a 32-pin general-purpose I/O port from a simple 32-bit register bus with a select, a write flag, a byte address and write data. Each pin has a direction bit and an output latch. The pad drivers see the direction bit as an output enable and the latch as the data value.

Software never needs to read a register, change it and write it back. Direction changes go through two set-only registers: one switches pins to output and the other switches pins to input. Output values go through two half-port registers. Each write to one of them carries a 16-bit enable mask in its upper half and 16 new pin values in its lower half. Only the enabled pins change, so two agents can update different pins without a lock.

The pad inputs pass through a two-stage synchronizer before they can be read back. The output latch keeps its value while a pin is an input. Software can therefore load the value first and then switch the pin to output without a glitch.

Top module: `gpio_mask_port`

## Requirements
- R1: A write to offset 0x00 sets the direction bit of every pin whose data bit is 1, which makes that pin an output. Pins whose data bit is 0 keep their direction.
- R2: A write to offset 0x04 clears the direction bit of every pin whose data bit is 1, which makes that pin an input. Pins whose data bit is 0 keep their direction.
- R3: A write to offset 0x08 updates the latches of pins 0 to 15. Data bit 16+k is the enable for pin k and data bit k is its new value.
- R4: A write to offset 0x0C updates the latches of pins 16 to 31. Data bit 16+k is the enable for pin 16+k and data bit k is its new value.
- R5: In a half-port write, a pin whose enable bit is 0 keeps its latch value. A write with an all-zero mask changes nothing.
- R6: The output latch can be written, and holds its value, while its pin is an input. Switching the pin to output then drives the latched value.
- R7: A read of offset 0x10 returns the synchronized pad levels. A pad change shows up after two rising clock edges and not after one.
- R8: After reset every pin is an input (direction 0) and every output latch is 0.
- R9: padOe equals the direction vector and padOut equals the latch vector, both one edge after the write that changes them.
- R10: Reads of 0x00 and 0x04 return the direction vector (1 = output). Reads of 0x08 and 0x0C return the matching latch half in bits 15:0 with zeros above. Unmapped offsets read 0, and busRdata is 0 when no read is in progress.
- R11: Writes to offset 0x10 or to unmapped offsets change neither direction nor latches, and at most one write strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address; bits 1:0 are ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational during a read |
| padIn | input | 32 | Asynchronous pad input levels |
| padOe | output | 32 | Per-pin output enable |
| padOut | output | 32 | Per-pin output value |

## Verification
The bench builds the block with its default parameters: a 32-bit data width, which gives two 16-pin halves, an 8-bit address and two synchronizer stages. At these values the bench can write to both halves with full, partial and empty masks, and can hit the mask bit at each edge of a half (bits 16 and 31). It can also land a read exactly one edge and two edges after a pad change, so the synchronizer latency is pinned to the cycle. The read scoreboard compares every readback of the direction, latch and pin offsets against a model driven only by the written data.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  // Word indexes (byte offset / 4) of the register windows
  localparam int unsigned WIDX_SET_OUT = 0;
  localparam int unsigned WIDX_SET_IN  = 1;
  localparam int unsigned WIDX_OUT_LO  = 2;
  localparam int unsigned WIDX_OUT_HI  = 3;
  localparam int unsigned WIDX_PIN     = 4;

  // Strobes from decode to datapath, at most one active per cycle
  typedef struct packed {
    logic setOut;
    logic setIn;
    logic wrLow;
    logic wrHigh;
  } gpioStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_DIR,
    RD_OUT_LO,
    RD_OUT_HI,
    RD_PIN
  } gpioRdSel_t;

endpackage

// File: rtl/gpio_mask_ctrl.sv
module gpio_mask_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output gpioStrobe_t       strobe,
  output gpioRdSel_t        rdSel
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic wrEn;
  logic rdEn;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrEn    = busSel && busWr;
  assign rdEn    = busSel && !busWr;

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      case (wordIdx)
        WORD_W'(WIDX_SET_OUT): strobe.setOut = 1'b1;
        WORD_W'(WIDX_SET_IN):  strobe.setIn  = 1'b1;
        WORD_W'(WIDX_OUT_LO):  strobe.wrLow  = 1'b1;
        WORD_W'(WIDX_OUT_HI):  strobe.wrHigh = 1'b1;
        default:               strobe = '0;
      endcase
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (rdEn) begin
      case (wordIdx)
        WORD_W'(WIDX_SET_OUT),
        WORD_W'(WIDX_SET_IN):  rdSel = RD_DIR;
        WORD_W'(WIDX_OUT_LO):  rdSel = RD_OUT_LO;
        WORD_W'(WIDX_OUT_HI):  rdSel = RD_OUT_HI;
        WORD_W'(WIDX_PIN):     rdSel = RD_PIN;
        default:               rdSel = RD_NONE;
      endcase
    end
  end

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  p_read_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |-> (strobe == '0));

  p_idle_no_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (rdSel == RD_NONE));

endmodule

// File: rtl/gpio_mask_datapath.sv
module gpio_mask_datapath
  import gpio_mask_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStrobe_t       strobe,
  input  logic [DATA_W-1:0] wdata,
  input  gpioRdSel_t        rdSel,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] dirQ,
  output logic [DATA_W-1:0] outQ,
  output logic [DATA_W-1:0] rdata
);

  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0] wrMask;
  logic [HALF-1:0] wrVal;
  logic [DATA_W-1:0] syncQ [SYNC_STAGES];
  logic [DATA_W-1:0] pinLevel;

  assign wrMask = wdata[DATA_W-1:HALF];
  assign wrVal  = wdata[HALF-1:0];

  // Direction: set-only and clear-only windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
    end else if (strobe.setOut) begin
      dirQ <= dirQ | wdata;
    end else if (strobe.setIn) begin
      dirQ <= dirQ & ~wdata;
    end
  end

  // Output latches, one masked half per window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0;
    end else begin
      if (strobe.wrLow) begin
        outQ[HALF-1:0] <= (outQ[HALF-1:0] & ~wrMask) | (wrVal & wrMask);
      end
      if (strobe.wrHigh) begin
        outQ[DATA_W-1:HALF] <= (outQ[DATA_W-1:HALF] & ~wrMask) | (wrVal & wrMask);
      end
    end
  end

  // Input synchronizer chain
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= '0;
        else       syncQ[g] <= padIn;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= '0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign pinLevel = syncQ[SYNC_STAGES-1];

  always_comb begin
    case (rdSel)
      RD_DIR:    rdata = dirQ;
      RD_OUT_LO: rdata = {{HALF{1'b0}}, outQ[HALF-1:0]};
      RD_OUT_HI: rdata = {{HALF{1'b0}}, outQ[DATA_W-1:HALF]};
      RD_PIN:    rdata = pinLevel;
      default:   rdata = '0;
    endcase
  end

  p_set_out_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOut |=> ((dirQ & $past(wdata)) == $past(wdata))
                   && ((dirQ & ~$past(wdata)) == ($past(dirQ) & ~$past(wdata))));

  p_set_in_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setIn |=> ((dirQ & $past(wdata)) == '0)
                  && ((dirQ & ~$past(wdata)) == ($past(dirQ) & ~$past(wdata))));

  p_low_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLow |=> (((outQ[HALF-1:0] ^ $past(outQ[HALF-1:0])) & ~$past(wrMask)) == '0)
                  && (outQ[DATA_W-1:HALF] == $past(outQ[DATA_W-1:HALF])));

  p_high_mask_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrHigh |=> (((outQ[DATA_W-1:HALF] ^ $past(outQ[DATA_W-1:HALF])) & ~$past(wrMask)) == '0)
                   && (outQ[HALF-1:0] == $past(outQ[HALF-1:0])));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrLow || strobe.wrHigh) |=> $stable(outQ));

  p_dir_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.setOut || strobe.setIn) |=> $stable(dirQ));

  p_sync_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (syncQ[0] == $past(padIn)));

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOe,
  output logic [DATA_W-1:0] padOut
);

  gpioStrobe_t strobe;
  gpioRdSel_t  rdSel;

  gpio_mask_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_mask_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wdata (busWdata),
    .rdSel (rdSel),
    .padIn (padIn),
    .dirQ  (padOe),
    .outQ  (padOut),
    .rdata (busRdata)
  );

  p_reset_r8: assert property (@(posedge clk) $fell(rstN) |=> (padOe == '0) && (padOut == '0));

endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOe;
  logic [31:0] padOut;

  int checks = 0;
  int failures = 0;
  expItem_t expQ[$];
  logic [31:0] dirM = '0;
  logic [31:0] outM = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOe(padOe), .padOut(padOut)
  );

  task automatic report(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // Driver: a write, with the model updated from the requirement text
  task automatic doWrite(logic [7:0] addr, logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWdata = d;
    case (addr)
      8'h00: dirM = dirM | d;
      8'h04: dirM = dirM & ~d;
      8'h08: outM[15:0]  = (outM[15:0]  & ~d[31:16]) | (d[15:0] & d[31:16]);
      8'h0C: outM[31:16] = (outM[31:16] & ~d[31:16]) | (d[15:0] & d[31:16]);
      default: ;
    endcase
  endtask

  // Driver: a read, expected value pushed to the scoreboard
  task automatic doRead(logic [7:0] addr, logic [31:0] exp, string req);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = addr; busWdata = '0;
    expQ.push_back('{exp: exp, req: req});
  endtask

  task automatic idle();
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic checkPads(string req);
    idle();
    #2;
    report(req, "padOe", padOe, dirM);
    report(req, "padOut", padOut, outM);
  endtask

  // Monitor: pops and compares each read result
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (busSel && !busWr) begin
        if (expQ.size() == 0) begin
          report("R10", "unexpected read", busRdata, 32'hXXXX_XXXX);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          report(it.req, "read", busRdata, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    padIn = 32'h0F0F_0F0F;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: reset state
    checkPads("R8");
    doRead(8'h00, 32'h0, "R8");
    doRead(8'h08, 32'h0, "R8");

    // R3, R6: load low half while every pin is an input
    doWrite(8'h08, 32'hFFFF_A5A5);
    checkPads("R6");
    doRead(8'h08, 32'h0000_A5A5, "R3");

    // R1, R9, R6: switch low byte to output, latched value is driven
    doWrite(8'h00, 32'h0000_00FF);
    checkPads("R9");
    doRead(8'h00, 32'h0000_00FF, "R10");
    doRead(8'h04, 32'h0000_00FF, "R10");

    // R1: zero bits leave the other pins alone
    doWrite(8'h00, 32'h0001_0000);
    checkPads("R1");

    // R2: set-input window
    doWrite(8'h04, 32'h0000_000F);
    checkPads("R2");
    doRead(8'h00, 32'h0001_00F0, "R2");

    // R5: partial mask on the low half
    doWrite(8'h08, 32'h00F0_0000);
    checkPads("R5");
    doRead(8'h08, 32'h0000_A505, "R5");

    // R4: high half full write, then mask bits at both ends
    doWrite(8'h0C, 32'hFFFF_1234);
    checkPads("R4");
    doWrite(8'h0C, 32'h8001_8000);
    checkPads("R4");
    doRead(8'h0C, 32'h0000_9234, "R4");
    doRead(8'h08, 32'h0000_A505, "R4");

    // R5: empty mask changes nothing
    doWrite(8'h08, 32'h0000_FFFF);
    doWrite(8'h0C, 32'h0000_FFFF);
    checkPads("R5");

    // R11: writes to the pin window and to unmapped offsets
    doWrite(8'h10, 32'hFFFF_FFFF);
    doWrite(8'h20, 32'hFFFF_FFFF);
    doWrite(8'h3C, 32'hFFFF_FFFF);
    checkPads("R11");
    doRead(8'h00, 32'h0001_00F0, "R11");

    // R10: unmapped read and idle bus
    doRead(8'h24, 32'h0, "R10");
    idle();
    #2;
    report("R10", "idle rdata", busRdata, 32'h0);

    // R7: synchronizer latency, two patterns
    doRead(8'h10, 32'h0F0F_0F0F, "R7");
    @(negedge clk);
    busSel = 1'b0;
    padIn = 32'hDEAD_BEEF;
    doRead(8'h10, 32'h0F0F_0F0F, "R7");
    doRead(8'h10, 32'hDEAD_BEEF, "R7");
    @(negedge clk);
    busSel = 1'b0;
    padIn = 32'h1234_5678;
    doRead(8'h10, 32'hDEAD_BEEF, "R7");
    doRead(8'h10, 32'h1234_5678, "R7");

    // R6, R9: latch value survives a round trip through input mode
    doWrite(8'h04, 32'hFFFF_FFFF);
    doWrite(8'h0C, 32'hFFFF_00AA);
    checkPads("R6");
    doWrite(8'h00, 32'hFFFF_0000);
    checkPads("R9");

    idle();
    idle();
    report("R10", "scoreboard drained", 32'(expQ.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule